// File: doc/BRIEF.md
# Mailbox Message Sender Engine

This engine pushes one message out through the sender side of a channelled mailbox. It is started with a one-cycle pulse that carries the message length in bytes. It pulls 32-bit payload words from a valid/ready stream and writes them into the mailbox channel registers. It holds an access request for the whole transfer. It reads the implemented channel count once, at the start.

The highest channel acts as a doorbell. Channel 0 carries the byte length in the first round, and payload fills the remaining channels in ascending order. When the channel index reaches the doorbell, the engine rings it with a fixed value and polls its status until the peer clears it. The next round then starts again at channel 0. When the payload runs out part way through a round, one last ring is sent. A round that ended exactly full has already rung, so no extra ring follows it. The engine then drops the access request and pulses done. A channel count that is too small is refused with an error pulse.

Top module: `mbx_sender`

## Requirements
- R1: `acc_req` rises on an accepted start. No channel write (`ch_wr`) occurs before `acc_rdy` has been seen high.
- R2: The first channel write of a transfer goes to channel 0, and its data is the byte length taken at start, zero-extended.
- R3: The payload is ceil(length/4) words. The words go out in stream order. Round one uses channels 1 up to doorbell−1, and later rounds use channels 0 up to doorbell−1.
- R4: The doorbell channel is `cfg_chans`−1. It is only ever written with the value 1234 and never carries payload.
- R5: After a ring, `st_rd` stays high with `st_idx` at the doorbell channel, and no write occurs until `st_rdata` reads zero. The next write then goes to channel 0.
- R6: When the payload ends with a nonzero channel index, one final ring is sent. When the last round ended exactly at the doorbell, no extra ring is sent. A zero-length message still rings once, after the length word.
- R7: After the final acknowledge, `done` is high for exactly one cycle. `acc_req` is low in that same cycle.
- R8: A start with `cfg_chans` below 3 gives an `err` pulse one cycle later. It makes no access request and no write.
- R9: A start pulse during a transfer is ignored. The message on the channels is unchanged, and no second transfer follows.
- R10: `pay_ready` is high only while payload words remain, so exactly ceil(length/4) stream handshakes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (pulse, taken only when idle) |
| msg_len | input | LEN_W | Message length in bytes, sampled at start |
| cfg_chans | input | CH_W+1 | Implemented channel count, sampled at start |
| pay_data | input | DW | Payload word |
| pay_valid | input | 1 | Payload word valid |
| pay_ready | output | 1 | Engine accepts a payload word |
| acc_req | output | 1 | Mailbox access request |
| acc_rdy | input | 1 | Mailbox access granted |
| ch_wr | output | 1 | Channel set-register write strobe |
| ch_idx | output | CH_W | Channel being written |
| ch_wdata | output | DW | Value written to the channel |
| st_rd | output | 1 | Channel status read strobe |
| st_idx | output | CH_W | Channel whose status is read |
| st_rdata | input | DW | Status of the channel selected by st_idx (same cycle) |
| done | output | 1 | Transfer complete, one cycle |
| err | output | 1 | Start refused, one cycle |

## Verification
`err` comes one register after the start edge, so the bench samples it at the first falling edge after that edge and expects it low one cycle later. Channel writes are combinational from the engine state, so each is logged at the falling edge of the cycle it occurs in. The gap from a ring to the next write must be at least the peer's clear latency plus two cycles: one cycle to see zero status and one to re-enter payload. `done` and the fall of `acc_req` share one register edge, so both are checked in the same sample, and `done` must be low again in the next one.

// File: rtl/mbx_send_pkg.sv
package mbx_send_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_LEN,
        ST_PAY,
        ST_NOTE,
        ST_POLL
    } tx_state_e;

    typedef struct packed {
        logic load;
        logic adv;
        logic rewind;
    } tx_ctl_t;

    localparam logic [31:0] DOORBELL  = 32'd1234;
    localparam int          MIN_CHANS = 3;

    // Number of 4-byte words needed to hold n bytes.
    function automatic logic [32:0] words_for(input logic [31:0] n);
        logic [32:0] padded;
        padded = {1'b0, n} + 33'd3;
        return padded >> 2;
    endfunction

endpackage

// File: rtl/mbx_round_ctr.sv
module mbx_round_ctr
    import mbx_send_pkg::*;
#(
    parameter int CH_W = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            adv,
    input  logic            rewind,
    input  logic [CH_W:0]   cfg_chans,
    output logic [CH_W-1:0] chan,
    output logic [CH_W-1:0] ctrl_idx,
    output logic            next_is_ctrl,
    output logic            chan_zero,
    output logic            cfg_short
);
    localparam logic [CH_W:0] MIN_CFG = (CH_W+1)'(MIN_CHANS);

    always_ff @(posedge clk) begin
        if (rst) begin
            chan     <= '0;
            ctrl_idx <= '0;
        end else if (load) begin
            // channel 0 takes the length word, payload begins at 1
            chan     <= CH_W'(1);
            ctrl_idx <= CH_W'(cfg_chans - 1'b1);
        end else if (rewind) begin
            chan <= '0;
        end else if (adv) begin
            chan <= chan + CH_W'(1);
        end
    end

    assign next_is_ctrl = (chan + CH_W'(1)) == ctrl_idx;
    assign chan_zero    = (chan == '0);
    assign cfg_short    = (cfg_chans < MIN_CFG);

endmodule

// File: rtl/mbx_word_ctr.sv
module mbx_word_ctr
    import mbx_send_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             dec,
    input  logic [LEN_W-1:0] msg_len,
    output logic             left_zero
);
    localparam int WC_W = LEN_W - 1;

    logic [WC_W-1:0] remaining;
    logic [32:0]     words_full;

    assign words_full = words_for(32'(msg_len));

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= words_full[WC_W-1:0];
        end else if (dec) begin
            remaining <= remaining - WC_W'(1);
        end
    end

    assign left_zero = (remaining == '0);

endmodule

// File: rtl/mbx_tx_fsm.sv
module mbx_tx_fsm
    import mbx_send_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      cfg_short,
    input  logic      acc_rdy,
    input  logic      pay_valid,
    input  logic      left_zero,
    input  logic      next_is_ctrl,
    input  logic      chan_zero,
    input  logic      st_zero,
    output tx_state_e state,
    output tx_ctl_t   ctl,
    output logic      pay_ready,
    output logic      acc_req,
    output logic      done,
    output logic      err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            acc_req <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (cfg_short) begin
                            err <= 1'b1;
                        end else begin
                            state   <= ST_REQ;
                            acc_req <= 1'b1;
                        end
                    end
                end
                ST_REQ:  if (acc_rdy) state <= ST_LEN;
                ST_LEN:  state <= ST_PAY;
                ST_PAY: begin
                    if (left_zero) begin
                        if (chan_zero) begin
                            state   <= ST_IDLE;
                            acc_req <= 1'b0;
                            done    <= 1'b1;
                        end else begin
                            state <= ST_NOTE;
                        end
                    end else if (pay_valid && next_is_ctrl) begin
                        state <= ST_NOTE;
                    end
                end
                ST_NOTE: state <= ST_POLL;
                ST_POLL: if (st_zero) state <= ST_PAY;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.load   = (state == ST_IDLE) && start && !cfg_short;
        ctl.adv    = (state == ST_PAY) && pay_valid && !left_zero;
        ctl.rewind = (state == ST_POLL) && st_zero;
        pay_ready  = (state == ST_PAY) && !left_zero;
    end

endmodule

// File: rtl/mbx_sender.sv
module mbx_sender
    import mbx_send_pkg::*;
#(
    parameter int CH_W  = 7,
    parameter int LEN_W = 16,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] msg_len,
    input  logic [CH_W:0]    cfg_chans,
    input  logic [DW-1:0]    pay_data,
    input  logic             pay_valid,
    output logic             pay_ready,
    output logic             acc_req,
    input  logic             acc_rdy,
    output logic             ch_wr,
    output logic [CH_W-1:0]  ch_idx,
    output logic [DW-1:0]    ch_wdata,
    output logic             st_rd,
    output logic [CH_W-1:0]  st_idx,
    input  logic [DW-1:0]    st_rdata,
    output logic             done,
    output logic             err
);
    tx_state_e       state;
    tx_ctl_t         ctl;
    logic [CH_W-1:0] chan;
    logic [CH_W-1:0] ctrl_idx;
    logic            next_is_ctrl;
    logic            chan_zero;
    logic            cfg_short;
    logic            left_zero;
    logic            st_zero;
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
        end else if (ctl.load) begin
            len_q <= msg_len;
        end
    end

    mbx_round_ctr #(.CH_W(CH_W)) u_round (
        .clk          (clk),
        .rst          (rst),
        .load         (ctl.load),
        .adv          (ctl.adv),
        .rewind       (ctl.rewind),
        .cfg_chans    (cfg_chans),
        .chan         (chan),
        .ctrl_idx     (ctrl_idx),
        .next_is_ctrl (next_is_ctrl),
        .chan_zero    (chan_zero),
        .cfg_short    (cfg_short)
    );

    mbx_word_ctr #(.LEN_W(LEN_W)) u_words (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.load),
        .dec       (ctl.adv),
        .msg_len   (msg_len),
        .left_zero (left_zero)
    );

    mbx_tx_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .cfg_short    (cfg_short),
        .acc_rdy      (acc_rdy),
        .pay_valid    (pay_valid),
        .left_zero    (left_zero),
        .next_is_ctrl (next_is_ctrl),
        .chan_zero    (chan_zero),
        .st_zero      (st_zero),
        .state        (state),
        .ctl          (ctl),
        .pay_ready    (pay_ready),
        .acc_req      (acc_req),
        .done         (done),
        .err          (err)
    );

    // Channel write port: length word, payload, or doorbell ring.
    always_comb begin
        ch_wr    = 1'b0;
        ch_idx   = '0;
        ch_wdata = '0;
        unique case (state)
            ST_LEN: begin
                ch_wr    = 1'b1;
                ch_wdata = DW'(len_q);
            end
            ST_PAY: begin
                ch_wr    = pay_valid && !left_zero;
                ch_idx   = chan;
                ch_wdata = pay_data;
            end
            ST_NOTE: begin
                ch_wr    = 1'b1;
                ch_idx   = ctrl_idx;
                ch_wdata = DW'(DOORBELL);
            end
            default: ;
        endcase
    end

    assign st_rd   = (state == ST_POLL);
    assign st_idx  = ctrl_idx;
    assign st_zero = (st_rdata == '0);

endmodule

// File: rtl/mbx_send_chk.sv
module mbx_send_chk #(
    parameter int CH_W = 7,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            ch_wr,
    input logic [CH_W-1:0] ch_idx,
    input logic [DW-1:0]   ch_wdata,
    input logic [CH_W-1:0] ctrl_idx,
    input logic            st_rd,
    input logic            acc_req,
    input logic            acc_rdy,
    input logic            pay_ready,
    input logic            done,
    input logic            err
);
    p_write_granted_r1: assert property (@(posedge clk) disable iff (rst)
        ch_wr |-> (acc_req && acc_rdy));

    p_bell_value_r4: assert property (@(posedge clk) disable iff (rst)
        (ch_wr && ch_idx == ctrl_idx) |-> (ch_wdata == DW'(32'd1234)));

    p_poll_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        st_rd |-> !ch_wr);

    p_release_done_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(acc_req) |-> done);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_err_no_access_r8: assert property (@(posedge clk) disable iff (rst)
        err |-> !acc_req);

    p_ready_in_transfer_r10: assert property (@(posedge clk) disable iff (rst)
        pay_ready |-> (acc_req && !st_rd));

    p_outcome_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, err}));

endmodule

bind mbx_sender mbx_send_chk #(.CH_W(CH_W), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ch_wr     (ch_wr),
    .ch_idx    (ch_idx),
    .ch_wdata  (ch_wdata),
    .ctrl_idx  (ctrl_idx),
    .st_rd     (st_rd),
    .acc_req   (acc_req),
    .acc_rdy   (acc_rdy),
    .pay_ready (pay_ready),
    .done      (done),
    .err       (err)
);

// File: tb/mbx_sender_tb.sv
module mbx_sender_tb;
    localparam int CH_W    = 7;
    localparam int LEN_W   = 16;
    localparam int DW      = 32;
    localparam int CLR_LAT = 4;
    localparam int ACC_LAT = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    logic             rst;
    logic             start;
    logic [LEN_W-1:0] msg_len;
    logic [CH_W:0]    cfg_chans;
    logic [DW-1:0]    pay_data;
    logic             pay_valid;
    logic             pay_ready;
    logic             acc_req;
    logic             acc_rdy;
    logic             ch_wr;
    logic [CH_W-1:0]  ch_idx;
    logic [DW-1:0]    ch_wdata;
    logic             st_rd;
    logic [CH_W-1:0]  st_idx;
    logic [DW-1:0]    st_rdata;
    logic             done;
    logic             err;

    mbx_sender #(.CH_W(CH_W), .LEN_W(LEN_W), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .msg_len(msg_len),
        .cfg_chans(cfg_chans), .pay_data(pay_data), .pay_valid(pay_valid),
        .pay_ready(pay_ready), .acc_req(acc_req), .acc_rdy(acc_rdy),
        .ch_wr(ch_wr), .ch_idx(ch_idx), .ch_wdata(ch_wdata), .st_rd(st_rd),
        .st_idx(st_idx), .st_rdata(st_rdata), .done(done), .err(err)
    );

    int n_chk = 0;
    int n_bad = 0;

    // ---------------- peer and source models ----------------
    int          cyc = 0;
    int          acc_cnt;
    int          ctrl_ch = 2;
    logic [DW-1:0] bell;
    int          bell_cnt;
    logic        gap_mode = 1'b0;
    logic        src_on = 1'b0;
    logic        src_clr = 1'b0;
    int          src_idx;
    logic [DW-1:0] base = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (rst || !acc_req) begin
            acc_rdy <= 1'b0;
            acc_cnt <= 0;
        end else if (acc_cnt < ACC_LAT) begin
            acc_cnt <= acc_cnt + 1;
        end else begin
            acc_rdy <= 1'b1;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            bell     <= '0;
            bell_cnt <= 0;
        end else if (ch_wr && ch_idx == ctrl_ch[CH_W-1:0]) begin
            bell     <= ch_wdata;
            bell_cnt <= CLR_LAT;
        end else if (bell_cnt > 0) begin
            bell_cnt <= bell_cnt - 1;
            if (bell_cnt == 1) bell <= '0;
        end
    end

    assign st_rdata = (st_rd && st_idx == ctrl_ch[CH_W-1:0]) ? bell : '0;

    always @(posedge clk) begin
        if (rst || src_clr) src_idx <= 0;
        else if (pay_valid && pay_ready) src_idx <= src_idx + 1;
    end

    assign pay_valid = src_on && (!gap_mode || (cyc % 3 != 0));
    assign pay_data  = base + DW'(src_idx);

    // ---------------- monitor ----------------
    int            log_n;
    int            log_idx [256];
    logic [DW-1:0] log_dat [256];
    int            log_t   [256];
    int            hs_n;
    int            viol_acc;

    always @(negedge clk) begin
        if (ch_wr && log_n < 256) begin
            log_idx[log_n] = int'(ch_idx);
            log_dat[log_n] = ch_wdata;
            log_t[log_n]   = cyc;
            log_n          = log_n + 1;
        end
        if (ch_wr && !acc_rdy) viol_acc = viol_acc + 1;
        if (pay_valid && pay_ready) hs_n = hs_n + 1;
    end

    // ---------------- expected sequence ----------------
    int            exp_n;
    int            exp_idx [256];
    logic [DW-1:0] exp_dat [256];

    task automatic push_exp(int idx, logic [DW-1:0] d);
        exp_idx[exp_n] = idx;
        exp_dat[exp_n] = d;
        exp_n = exp_n + 1;
    endtask

    task automatic build_exp(int len, int nch);
        int ctl = nch - 1;
        int ch  = 1;
        int wds = (len + 3) / 4;
        exp_n = 0;
        push_exp(0, DW'(len));
        for (int i = 0; i < wds; i++) begin
            push_exp(ch, base + DW'(i));
            ch = ch + 1;
            if (ch == ctl) begin
                push_exp(ctl, DW'(1234));
                ch = 0;
            end
        end
        if (ch != 0) push_exp(ctl, DW'(1234));
    endtask

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst = 1'b1; start = 1'b0; msg_len = '0; cfg_chans = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!acc_req && !done && !err && !ch_wr && !pay_ready && !st_rd,
            "R1", "outputs idle after reset",
            int'({acc_req, done, err, ch_wr, pay_ready, st_rd}), 0);
    endtask

    // Runs one transfer and checks it; mid > 0 injects a start at that cycle.
    task automatic t_xfer(int len, int nch, bit gaps, int mid, string req);
        bit   seen = 0;
        int   wds  = (len + 3) / 4;
        int   bad_data = 0;
        int   bad_bell = 0;
        int   bad_gap  = 0;
        int   snap_n;
        logic acc_at_done = 1'b1;
        logic [DW-1:0] bell_at_done = '1;
        @(posedge clk); #1;
        ctrl_ch   = nch - 1;
        cfg_chans = (CH_W+1)'(nch);
        msg_len   = LEN_W'(len);
        base      = 32'h0000_A000 + DW'(len * 16);
        gap_mode  = gaps;
        src_clr   = 1'b1;
        log_n = 0; hs_n = 0; viol_acc = 0;
        @(posedge clk); #1;
        src_clr = 1'b0;
        src_on  = 1'b1;
        build_exp(len, nch);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (mid > 0 && k == mid) begin
                start   = 1'b1;
                msg_len = LEN_W'(len + 40);
            end else if (mid > 0 && k == mid + 1) begin
                start = 1'b0;
            end
            if (done) begin
                seen         = 1;
                acc_at_done  = acc_req;
                bell_at_done = bell;
                break;
            end
        end
        start = 1'b0;
        chk(seen, "R7", "done seen", int'(seen), 1);
        chk(acc_at_done == 1'b0, "R7", "acc_req low with done", int'(acc_at_done), 0);
        chk(bell_at_done == '0, "R7", "done only after last acknowledge", int'(bell_at_done), 0);
        @(negedge clk);
        chk(!done, "R7", "done one cycle only", int'(done), 0);
        chk(viol_acc == 0, "R1", "writes before access ready", viol_acc, 0);
        chk(log_n > 0 && log_idx[0] == 0 && log_dat[0] == DW'(len), "R2",
            "length word on channel 0", int'(log_dat[0]), len);
        chk(log_n == exp_n, req, "number of channel writes", log_n, exp_n);
        for (int i = 0; i < log_n && i < exp_n; i++) begin
            if (log_idx[i] != exp_idx[i] || log_dat[i] != exp_dat[i]) bad_data++;
            if (log_idx[i] == ctrl_ch && log_dat[i] != DW'(1234)) bad_bell++;
            if (i + 1 < log_n && log_idx[i] == ctrl_ch && log_t[i+1] - log_t[i] < CLR_LAT + 2)
                bad_gap++;
            if (i + 1 < log_n && log_idx[i] == ctrl_ch && log_idx[i+1] != 0) bad_gap++;
        end
        chk(bad_data == 0, "R3", "payload order and channels", bad_data, 0);
        chk(bad_bell == 0, "R4", "doorbell carries only 1234", bad_bell, 0);
        chk(bad_gap == 0, "R5", "wait for clear then restart at channel 0", bad_gap, 0);
        chk(hs_n == wds, "R10", "stream handshakes", hs_n, wds);
        snap_n = log_n;
        repeat (20) @(negedge clk);
        chk(log_n == snap_n && !acc_req, "R9", "no activity after done",
            log_n - snap_n, 0);
        src_on = 1'b0;
    endtask

    task automatic t_short_cfg();
        bit any_acc = 0;
        @(posedge clk); #1;
        log_n = 0;
        cfg_chans = (CH_W+1)'(2);
        msg_len   = LEN_W'(8);
        start     = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        chk(err, "R8", "err one cycle after start", int'(err), 1);
        chk(!acc_req, "R8", "no access request on refusal", int'(acc_req), 0);
        @(negedge clk);
        chk(!err, "R8", "err one cycle only", int'(err), 0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (acc_req) any_acc = 1;
        end
        chk(!any_acc && log_n == 0, "R8", "no writes after refusal", log_n, 0);
    endtask

    initial begin
        t_reset();
        t_xfer(10, 5, 1'b0, 0, "R6");   // exactly full single round, no extra ring
        t_xfer(21, 4, 1'b1, 0, "R6");   // three rounds, final ring from index 1
        t_xfer(0, 3, 1'b0, 0, "R6");    // length only, one ring
        t_xfer(7, 8, 1'b1, 0, "R3");    // partial single round
        t_xfer(100, 3, 1'b1, 0, "R5");  // many two-slot rounds
        t_short_cfg();
        t_xfer(10, 5, 1'b0, 6, "R9");   // start pulse while busy
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule